// File: doc/BRIEF.md
# Configuration Write Protection Guard

This block stands between a peripheral's configuration write path and its configuration registers. Every incoming write carries a command kind and a protected-write enable. The guard keeps two 32-bit protection vectors: a lock vector, which software may set and clear, and a commit vector, which software may only set and which only reset clears. A configuration write is turned into a one-cycle, one-hot write-enable for the target register only if the enable was asserted, the register exists, and neither its lock bit nor its commit bit is set.

The registers themselves live outside the block. The guard forwards the write data alongside the registered write-enable. It also exposes both protection vectors so the surrounding logic can read them back. Twelve positions of the vector are protectable: 0, 1, 2, 3, 4, 7, 14, 15, 16, 23, 26 and 29. These correspond to run enable, two control words, start address, seed, golden value, watchdog configuration, watchdog lower and upper window bounds, NMI force, interrupt enable and interrupt force. All other positions have no register behind them.

Top module: `reg_guard`

## Requirements
- R1: While and after reset, `lock_state`, `commit_state` and `cfg_we` are all zero.
- R2: A write with `wr_kind`=0 (configuration), `wr_prot_en`=1, to an implemented, unprotected index raises exactly bit `wr_index` of `cfg_we` for the one cycle after the write edge, with `cfg_wdata` equal to the written data.
- R3: Any write made with `wr_prot_en`=0 is dropped: no `cfg_we` bit rises, and lock and commit vectors are unchanged.
- R4: A configuration write to an index whose lock bit is set produces no write-enable.
- R5: A write with `wr_kind`=1 (lock set) ORs `wr_data` into the lock vector, limited to the implemented positions 0,1,2,3,4,7,14,15,16,23,26,29.
- R6: A write with `wr_kind`=2 (lock clear) clears the lock bits selected by `wr_data`, except those whose commit bit is set.
- R7: A write with `wr_kind`=3 (commit) ORs `wr_data` into the commit vector at implemented positions; commit bits are never cleared except by reset, and a committed index produces no write-enable.
- R8: Indices and vector positions outside the implemented set never produce a write-enable and always read as zero.
- R9: `cfg_we` has at most one bit set in any cycle and returns to zero in the cycle after a write unless another accepted write follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request this cycle |
| wr_kind | input | 2 | 0 config, 1 lock set, 2 lock clear, 3 commit |
| wr_index | input | 5 | Target register index for configuration writes |
| wr_data | input | 32 | Configuration data or protection bit mask |
| wr_prot_en | input | 1 | Protected-write enable |
| cfg_we | output | 32 | One-hot registered write-enable per register |
| cfg_wdata | output | 32 | Data aligned with `cfg_we` |
| lock_state | output | 32 | Current lock vector |
| commit_state | output | 32 | Current commit vector |

## Verification
The bench targets a lock clear aimed at committed positions; a design that let it through would leave a committed register with its lock bit silently removed. It issues a commit of an all-zero mask and lock writes with the enable low; a design that treated commit as a plain store or ignored the enable would change the protection vectors. It writes to unimplemented index 5 and sets all 32 lock bits; a design without the position mask would emit a stray strobe or report phantom lock bits. A mid-run reset is followed by a write to a previously committed index, which must succeed because reset must clear the commit vector.

// File: rtl/reg_guard_pkg.sv
package reg_guard_pkg;

    localparam int unsigned NREG = 32;
    localparam int unsigned IDXW = $clog2(NREG);

    // positions that have a register behind them
    localparam logic [NREG-1:0] IMPL_DEFAULT = 32'h2481_C09F;

    typedef enum logic [1:0] {
        K_CFG      = 2'd0,
        K_LOCK_SET = 2'd1,
        K_LOCK_CLR = 2'd2,
        K_COMMIT   = 2'd3
    } wr_kind_e;

    typedef struct packed {
        logic [NREG-1:0] lock;
        logic [NREG-1:0] commit;
        logic [NREG-1:0] we;
        logic [31:0]     wdata;
    } guard_state_t;

endpackage

// File: rtl/guard_onehot.sv
module guard_onehot #(
    parameter int unsigned N  = 32,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic          en,
    input  logic [IW-1:0] idx,
    output logic [N-1:0]  oh
);
    for (genvar i = 0; i < N; i++) begin : g_dec
        assign oh[i] = en && (idx == IW'(i));
    end
endmodule

// File: rtl/guard_bit_cell.sv
module guard_bit_cell (
    input  logic lock_q,
    input  logic commit_q,
    input  logic set_req,
    input  logic clr_req,
    input  logic commit_req,
    output logic lock_d,
    output logic commit_d
);
    // a committed bit refuses to be unlocked
    assign lock_d   = (lock_q | set_req) & ~(clr_req & ~commit_q);
    assign commit_d = commit_q | commit_req;
endmodule

// File: rtl/reg_guard.sv
module reg_guard
    import reg_guard_pkg::*;
#(
    parameter logic [NREG-1:0] IMPL_MASK = IMPL_DEFAULT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_valid,
    input  logic [1:0]      wr_kind,
    input  logic [IDXW-1:0] wr_index,
    input  logic [31:0]     wr_data,
    input  logic            wr_prot_en,
    output logic [NREG-1:0] cfg_we,
    output logic [31:0]     cfg_wdata,
    output logic [NREG-1:0] lock_state,
    output logic [NREG-1:0] commit_state
);

    guard_state_t st_d, st_q;

    logic            acc;
    logic            is_cfg, is_set, is_clr, is_com;
    logic [NREG-1:0] sel_oh;
    logic [NREG-1:0] lock_n, commit_n;
    logic [NREG-1:0] we_ok;

    assign acc    = wr_valid && wr_prot_en;
    assign is_cfg = acc && (wr_kind_e'(wr_kind) == K_CFG);
    assign is_set = acc && (wr_kind_e'(wr_kind) == K_LOCK_SET);
    assign is_clr = acc && (wr_kind_e'(wr_kind) == K_LOCK_CLR);
    assign is_com = acc && (wr_kind_e'(wr_kind) == K_COMMIT);

    guard_onehot #(.N(NREG), .IW(IDXW)) dec_i (
        .en  (is_cfg),
        .idx (wr_index),
        .oh  (sel_oh)
    );

    for (genvar b = 0; b < NREG; b++) begin : g_bit
        if (IMPL_MASK[b]) begin : g_live
            guard_bit_cell cell_i (
                .lock_q     (st_q.lock[b]),
                .commit_q   (st_q.commit[b]),
                .set_req    (is_set && wr_data[b]),
                .clr_req    (is_clr && wr_data[b]),
                .commit_req (is_com && wr_data[b]),
                .lock_d     (lock_n[b]),
                .commit_d   (commit_n[b])
            );
        end else begin : g_tie
            assign lock_n[b]   = 1'b0;
            assign commit_n[b] = 1'b0;
        end
    end

    assign we_ok = sel_oh & IMPL_MASK & ~(st_q.lock | st_q.commit);

    always_comb begin
        st_d        = st_q;
        st_d.lock   = lock_n;
        st_d.commit = commit_n;
        st_d.we     = we_ok;
        if (|we_ok) begin
            st_d.wdata = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_we       = st_q.we;
    assign cfg_wdata    = st_q.wdata;
    assign lock_state   = st_q.lock;
    assign commit_state = st_q.commit;

endmodule

// File: rtl/reg_guard_chk.sv
module reg_guard_chk #(
    parameter logic [31:0] IMPL_MASK = 32'h2481_C09F
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_valid,
    input logic        wr_prot_en,
    input logic [31:0] cfg_we,
    input logic [31:0] lock_state,
    input logic [31:0] commit_state
);
    // R9
    we_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cfg_we));

    // R7
    commit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((commit_state & $past(commit_state)) == $past(commit_state)));

    // R3
    no_enable_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && wr_prot_en) |=> (cfg_we == '0 && $stable(lock_state)
                                       && $stable(commit_state)));

    // R4
    protected_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cfg_we & $past(lock_state | commit_state)) == '0));

    // R8
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_we | lock_state | commit_state) & ~IMPL_MASK) == '0);

    // R6
    commit_keeps_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((lock_state ^ $past(lock_state)) & $past(lock_state)
                   & $past(commit_state)) == '0));
endmodule

bind reg_guard reg_guard_chk #(.IMPL_MASK(IMPL_MASK)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .wr_prot_en   (wr_prot_en),
    .cfg_we       (cfg_we),
    .lock_state   (lock_state),
    .commit_state (commit_state)
);

// File: tb/reg_guard_tb_top.sv
module reg_guard_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 19;

    typedef struct packed {
        logic [1:0]  kind;
        logic [4:0]  idx;
        logic [31:0] data;
        logic        prot;
        logic [31:0] exp_we;
        logic [31:0] exp_lock;
        logic [31:0] exp_com;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{2'd0, 5'd0,  32'h0000_A5A5, 1'b1, 32'h0000_0001, 32'h0, 32'h0, 8'd2},  // R2
        '{2'd0, 5'd7,  32'h0000_1111, 1'b0, 32'h0, 32'h0, 32'h0, 8'd3},          // R3
        '{2'd1, 5'd0,  32'hFFFF_FFFF, 1'b0, 32'h0, 32'h0, 32'h0, 8'd3},          // R3
        '{2'd1, 5'd0,  32'h0000_0081, 1'b1, 32'h0, 32'h0000_0081, 32'h0, 8'd5},  // R5
        '{2'd0, 5'd7,  32'h0000_2222, 1'b1, 32'h0, 32'h0000_0081, 32'h0, 8'd4},  // R4
        '{2'd0, 5'd1,  32'h0000_3333, 1'b1, 32'h0000_0002, 32'h0000_0081, 32'h0, 8'd2},
        '{2'd0, 5'd5,  32'h0000_4444, 1'b1, 32'h0, 32'h0000_0081, 32'h0, 8'd8},  // R8
        '{2'd1, 5'd0,  32'hFFFF_FFFF, 1'b1, 32'h0, 32'h2481_C09F, 32'h0, 8'd8},
        '{2'd2, 5'd0,  32'h0000_0080, 1'b1, 32'h0, 32'h2481_C01F, 32'h0, 8'd6},  // R6
        '{2'd0, 5'd7,  32'h0000_5555, 1'b1, 32'h0000_0080, 32'h2481_C01F, 32'h0, 8'd2},
        '{2'd3, 5'd0,  32'h0000_4001, 1'b1, 32'h0, 32'h2481_C01F, 32'h0000_4001, 8'd7}, // R7
        '{2'd2, 5'd0,  32'hFFFF_FFFF, 1'b1, 32'h0, 32'h0000_4001, 32'h0000_4001, 8'd6},
        '{2'd0, 5'd0,  32'h0000_6666, 1'b1, 32'h0, 32'h0000_4001, 32'h0000_4001, 8'd7},
        '{2'd0, 5'd2,  32'h0000_7777, 1'b1, 32'h0000_0004, 32'h0000_4001, 32'h0000_4001, 8'd2},
        '{2'd3, 5'd0,  32'h0000_0000, 1'b1, 32'h0, 32'h0000_4001, 32'h0000_4001, 8'd7},
        '{2'd0, 5'd14, 32'h0000_8888, 1'b1, 32'h0, 32'h0000_4001, 32'h0000_4001, 8'd7},
        '{2'd0, 5'd29, 32'h0000_9999, 1'b1, 32'h2000_0000, 32'h0000_4001, 32'h0000_4001, 8'd2},
        '{2'd3, 5'd0,  32'h2000_0000, 1'b0, 32'h0, 32'h0000_4001, 32'h0000_4001, 8'd3},
        '{2'd0, 5'd29, 32'h0000_BBBB, 1'b1, 32'h2000_0000, 32'h0000_4001, 32'h0000_4001, 8'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [1:0]  wr_kind = '0;
    logic [4:0]  wr_index = '0;
    logic [31:0] wr_data = '0;
    logic        wr_prot_en = 1'b0;
    logic [31:0] cfg_we, cfg_wdata, lock_state, commit_state;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reg_guard dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_valid     (wr_valid),
        .wr_kind      (wr_kind),
        .wr_index     (wr_index),
        .wr_data      (wr_data),
        .wr_prot_en   (wr_prot_en),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .lock_state   (lock_state),
        .commit_state (commit_state)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] k, input logic [4:0] i,
                         input logic [31:0] d, input logic p);
        wr_valid = 1'b1; wr_kind = k; wr_index = i; wr_data = d; wr_prot_en = p;
        @(negedge clk);
        wr_valid = 1'b0; wr_prot_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected <= 5000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 we", cfg_we, 32'h0);
        check("R1 lock", lock_state, 32'h0);
        check("R1 commit", commit_state, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            drive(VEC[v].kind, VEC[v].idx, VEC[v].data, VEC[v].prot);
            check($sformatf("R%0d vec%0d we", VEC[v].req, v), cfg_we, VEC[v].exp_we);
            check($sformatf("R%0d vec%0d lock", VEC[v].req, v), lock_state, VEC[v].exp_lock);
            check($sformatf("R%0d vec%0d commit", VEC[v].req, v), commit_state, VEC[v].exp_com);
            if (VEC[v].exp_we != 32'h0)
                check($sformatf("R2 vec%0d wdata", v), cfg_wdata, VEC[v].data);
        end

        // R9: strobe lasts one cycle
        @(negedge clk);
        check("R9 pulse end", cfg_we, 32'h0);

        // R9: back-to-back writes give one strobe each
        drive(2'd0, 5'd3, 32'h0000_00C3, 1'b1);
        check("R9 b2b first", cfg_we, 32'h0000_0008);
        drive(2'd0, 5'd4, 32'h0000_00C4, 1'b1);
        check("R9 b2b second", cfg_we, 32'h0000_0010);
        check("R2 b2b data", cfg_wdata, 32'h0000_00C4);

        // R1: reset mid-run clears commit and lock
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid lock", lock_state, 32'h0);
        check("R1 mid commit", commit_state, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        drive(2'd0, 5'd0, 32'h0000_F00D, 1'b1);
        check("R7 after reset we", cfg_we, 32'h0000_0001);

        finish_run();
    end

endmodule